// File: doc/BRIEF.md
# Two-Wire Controlled Dual Wiper Register

This block is the serial front end and register core of a dual-channel, 8-bit digital potentiometer. It listens on a two-wire bus (clock line and open-drain data line). Both lines are brought into the system clock domain through synchronizer chains, and bus start and stop conditions are recognized there. The block answers only to a 7-bit address built from a fixed 5-bit prefix and two strap pins, so four copies can share one bus.

A write transaction always has three bytes. The first is the address with the direction bit. The second is an instruction byte that picks one of the two channels. It can also recentre that channel's wiper, set or clear that channel's shutdown flag, and set two general-purpose logic outputs. The third byte is the new 8-bit wiper code for the chosen channel. A read transaction returns the wiper code of the channel most recently chosen by an instruction byte.

The outputs are the two wiper codes, a shutdown flag per channel and the two logic outputs. They go to the analog ladder and the pins next to it.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0b01011 followed by strap_i[1] then strap_i[0]. It acknowledges by asserting sda_oe_o (pulling the data line low) through the ninth clock pulse. After a non-matching address it never asserts sda_oe_o until the next start condition.
- R2: A falling data line while the clock line is high (start) restarts address reception from any state, including in the middle of a byte. A rising data line while the clock line is high (stop) returns the block to idle with sda_oe_o deasserted.
- R3: The instruction byte is received MSB first and acknowledged. Bit 7 selects the channel (0 = wiper_a_o, 1 = wiper_b_o). Bit 4 drives gpo_o[1] and bit 3 drives gpo_o[0]. Bits 2..0 have no effect.
- R4: The data byte is received MSB first and acknowledged. When it completes, it loads the wiper of the channel selected by the preceding instruction byte. The other wiper is left unchanged.
- R5: When instruction bit 6 is 1, the selected wiper becomes the midscale code 0x80 as soon as the instruction byte completes. A following data byte still overwrites it.
- R6: Instruction bit 5 is written into the selected channel's shutdown flag. shut_o[0] (channel A) and shut_o[1] (channel B) are each that flag OR the inverse of the active-low shdn_n_i pin.
- R7: A write that ends by stop or repeated start before its data byte completes does not change either wiper, except through the midscale bit of R5.
- R8: Bytes that follow the data byte within the same write are not acknowledged and change no output.
- R9: In a read, the block drives the selected channel's wiper code MSB first. It repeats the code after each master acknowledge, and releases the data line after a master non-acknowledge.
- R10: After reset both wipers are 0x80, shut_o and gpo_o are 0, channel A is selected and sda_oe_o is deasserted.
- R11: sda_oe_o changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap_i | input | 2 | Address strap pins, [1] then [0] form the two low address bits |
| shdn_n_i | input | 1 | Active-low shutdown pin for both channels |
| wiper_a_o | output | 8 | Wiper code of channel A |
| wiper_b_o | output | 8 | Wiper code of channel B |
| shut_o | output | 2 | Shutdown state, [0] channel A, [1] channel B |
| gpo_o | output | 2 | General-purpose logic outputs |

## Verification
Every cycle, assertions check the following. The data-line enable stays still while the synchronized clock is high. A stop always leaves the block idle and released. An idle block never drives the line. At most one byte strobe fires per cycle. Neither wiper moves without a strobe, and a midscale instruction lands on 0x80. Other behaviour can only be shown by whole transactions: the address comparison against the straps, the field decoding of the instruction byte, and the repeat-on-acknowledge of reads. The same holds for a truncated write leaving the wipers intact and for extra bytes being refused. The bench drives these transactions as a bus master and reads the results back over the bus.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_PREFIX_W = 5;
    localparam logic [ADDR_PREFIX_W-1:0] ADDR_PREFIX = 5'b01011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP,
        ST_RD,
        ST_RD_ACK,
        ST_RD_NEXT
    } link_st_e;
endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/dpot_link.sv
module dpot_link
    import dpot_pkg::*;
#(
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               sda_rise,
    input  logic               sda_fall,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_code_i,
    output logic               sda_oe_o,
    output logic               instr_stb_o,
    output logic               data_stb_o,
    output logic [BYTE_W-1:0]  rx_byte_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        link_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;
        logic [BYTE_W-1:0] tx;
        logic              oe;
        logic              rw;
    } link_s;

    link_s link_d, link_q;
    logic  start_ev, stop_ev;
    logic [BYTE_W-1:0] byte_in;

    assign start_ev = scl_lvl & sda_fall;
    assign stop_ev  = scl_lvl & sda_rise;
    assign byte_in  = {link_q.sr[BYTE_W-2:0], sda_lvl};

    always_comb begin
        link_d      = link_q;
        instr_stb_o = 1'b0;
        data_stb_o  = 1'b0;
        if (start_ev) begin
            link_d.st  = ST_ADDR;
            link_d.cnt = '0;
            link_d.oe  = 1'b0;
        end else if (stop_ev) begin
            link_d.st = ST_IDLE;
            link_d.oe = 1'b0;
        end else begin
            case (link_q.st)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (scl_rise) begin
                        link_d.sr  = byte_in;
                        link_d.cnt = link_q.cnt + 1'b1;
                        if (link_q.cnt == LAST_BIT) begin
                            if (link_q.st == ST_ADDR) begin
                                if (byte_in[BYTE_W-1:1] == {ADDR_PREFIX, strap_i}) begin
                                    link_d.st = ST_ADDR_ACK;
                                    link_d.rw = byte_in[0];
                                end else begin
                                    link_d.st = ST_IDLE;
                                end
                            end else if (link_q.st == ST_INSTR) begin
                                instr_stb_o = 1'b1;
                                link_d.st   = ST_INSTR_ACK;
                            end else begin
                                data_stb_o = 1'b1;
                                link_d.st  = ST_DATA_ACK;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        if (!link_q.oe) begin
                            link_d.oe = 1'b1;
                        end else begin
                            link_d.oe  = 1'b0;
                            link_d.cnt = '0;
                            if (link_q.st == ST_ADDR_ACK) begin
                                if (link_q.rw) begin
                                    link_d.st = ST_RD;
                                    link_d.tx = rd_code_i;
                                    link_d.oe = ~rd_code_i[BYTE_W-1];
                                end else begin
                                    link_d.st = ST_INSTR;
                                end
                            end else if (link_q.st == ST_INSTR_ACK) begin
                                link_d.st = ST_DATA;
                            end else begin
                                link_d.st = ST_SKIP;
                            end
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        link_d.cnt = link_q.cnt + 1'b1;
                        if (link_q.cnt == LAST_BIT) begin
                            link_d.oe = 1'b0;
                            link_d.st = ST_RD_ACK;
                        end else begin
                            link_d.tx = {link_q.tx[BYTE_W-2:0], 1'b0};
                            link_d.oe = ~link_q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) link_d.st = sda_lvl ? ST_SKIP : ST_RD_NEXT;
                end
                ST_RD_NEXT: begin
                    if (scl_fall) begin
                        link_d.st  = ST_RD;
                        link_d.cnt = '0;
                        link_d.tx  = rd_code_i;
                        link_d.oe  = ~rd_code_i[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= '{st: ST_IDLE, cnt: '0, sr: '0, tx: '0, oe: 1'b0, rw: 1'b0};
        end else begin
            link_q <= link_d;
        end
    end

    assign sda_oe_o  = link_q.oe;
    assign rx_byte_o = byte_in;

    // R11: data-line enable holds while the clock line is high
    assert_sda_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && !start_ev && !stop_ev) |=> $stable(link_q.oe));

    // R2: stop leaves the link idle and released
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!link_q.oe && link_q.st == ST_IDLE));

    // R1: an idle (or unaddressed) link never pulls the line
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q.st == ST_IDLE) |-> !link_q.oe);

    // R4: instruction and data strobes never coincide
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_stb_o, data_stb_o}));
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
    import dpot_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               shdn_n_i,
    output logic [BYTE_W-1:0]  wiper_a_o,
    output logic [BYTE_W-1:0]  wiper_b_o,
    output logic [1:0]         shut_o,
    output logic [1:0]         gpo_o
);
    localparam logic [BYTE_W-1:0] MID_CODE = BYTE_W'(1) << (BYTE_W - 1);
    localparam int BIT_SEL = BYTE_W - 1;
    localparam int BIT_MID = BYTE_W - 2;
    localparam int BIT_SHD = BYTE_W - 3;
    localparam int BIT_O2  = BYTE_W - 4;
    localparam int BIT_O1  = BYTE_W - 5;

    typedef struct packed {
        logic [BYTE_W-1:0] wa;
        logic [BYTE_W-1:0] wb;
        logic              sel;
        logic [1:0]        shd;
        logic [1:0]        gpo;
    } core_s;

    core_s core_d, core_q;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic instr_stb, data_stb;
    logic [BYTE_W-1:0] rx_byte, rd_code;

    dpot_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    dpot_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    assign rd_code = core_q.sel ? core_q.wb : core_q.wa;

    dpot_link #(.STRAP_W(STRAP_W)) u_link (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .strap_i(strap_i), .rd_code_i(rd_code),
        .sda_oe_o(sda_oe_o), .instr_stb_o(instr_stb), .data_stb_o(data_stb),
        .rx_byte_o(rx_byte));

    always_comb begin
        core_d = core_q;
        if (instr_stb) begin
            core_d.sel = rx_byte[BIT_SEL];
            core_d.gpo = {rx_byte[BIT_O2], rx_byte[BIT_O1]};
            core_d.shd[rx_byte[BIT_SEL]] = rx_byte[BIT_SHD];
            if (rx_byte[BIT_MID]) begin
                if (rx_byte[BIT_SEL]) core_d.wb = MID_CODE;
                else                  core_d.wa = MID_CODE;
            end
        end else if (data_stb) begin
            if (core_q.sel) core_d.wb = rx_byte;
            else            core_d.wa = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{wa: MID_CODE, wb: MID_CODE, sel: 1'b0, shd: 2'b00, gpo: 2'b00};
        end else begin
            core_q <= core_d;
        end
    end

    assign wiper_a_o = core_q.wa;
    assign wiper_b_o = core_q.wb;
    assign gpo_o     = core_q.gpo;
    assign shut_o    = core_q.shd | {2{~shdn_n_i}};

    // R7: wipers move only on a completed instruction or data byte
    assert_wiper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_stb && !data_stb) |=> ($stable(core_q.wa) && $stable(core_q.wb)));

    // R5: a midscale instruction for channel A lands on the center code
    assert_midscale_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_stb && rx_byte[BIT_MID] && !rx_byte[BIT_SEL]) |=> (wiper_a_o == MID_CODE));

    // R6: the shutdown pin forces both channels off
    assert_pin_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_i |-> (shut_o == 2'b11));
endmodule

// File: tb/tb_dpot_i2c_ctrl.sv
module tb_dpot_i2c_ctrl;
    localparam int Q = 10;
    localparam int NVEC = 6;
    localparam logic [7:0] WR_ADDR = 8'h5C;
    localparam logic [7:0] RD_ADDR = 8'h5D;

    // {instr, data, exp_a, exp_b, exp_gpo, exp_shut}
    localparam logic [35:0] VEC [NVEC] = '{
        {8'h00, 8'h3C, 8'h3C, 8'h80, 2'b00, 2'b00},
        {8'h80, 8'hA5, 8'h3C, 8'hA5, 2'b00, 2'b00},
        {8'h1F, 8'hFF, 8'hFF, 8'hA5, 2'b11, 2'b00},
        {8'hB0, 8'h00, 8'hFF, 8'h00, 2'b10, 2'b10},
        {8'h80, 8'h7E, 8'hFF, 8'h7E, 2'b00, 2'b00},
        {8'h20, 8'h01, 8'h01, 8'h7E, 2'b00, 2'b01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic shdn_n = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [7:0] wa, wb;
    logic [1:0] shut, gpo;
    int n_checks = 0;
    int n_errors = 0;
    int r11_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    dpot_i2c_ctrl dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .strap_i(2'b10), .shdn_n_i(shdn_n),
        .wiper_a_o(wa), .wiper_b_o(wb), .shut_o(shut), .gpo_o(gpo));

    // R11 monitor at the ports
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) r11_viol++;
        prev_scl = m_scl;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_low = 1'b1; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_low = 1'b0; qwait();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_low = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        nack = sda_bus; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            m_scl = 1'b1; qwait();
            b[i] = sda_bus; qwait();
            m_scl = 1'b0;
        end
        qwait();
        put_bit(~ack);
        m_low = 1'b0;
    endtask

    task automatic write3(input logic [7:0] ins, input logic [7:0] dat, input string req);
        logic nk;
        bus_start();
        send_byte(WR_ADDR, nk); chk({req, " R1 addr ack"}, nk, 0);
        send_byte(ins, nk);     chk({req, " R3 instr ack"}, nk, 0);
        send_byte(dat, nk);     chk({req, " R4 data ack"}, nk, 0);
        bus_stop();
    endtask

    task automatic read1(output logic [7:0] b);
        logic nk;
        bus_start();
        send_byte(RD_ADDR, nk); chk("R9 read addr ack", nk, 0);
        recv_byte(1'b0, b);
        bus_stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic nk;
        logic [7:0] rb, rb2;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk("R10 wiper_a", wa, 8'h80);
        chk("R10 wiper_b", wb, 8'h80);
        chk("R10 shut", shut, 0);
        chk("R10 gpo", gpo, 0);
        chk("R10 sda_oe", sda_oe, 0);
        rst_n = 1'b1;
        qwait();

        for (int v = 0; v < NVEC; v++) begin
            write3(VEC[v][35:28], VEC[v][27:20], "vec");
            chk("R4 wiper_a", wa, VEC[v][19:12]);
            chk("R4 wiper_b", wb, VEC[v][11:4]);
            chk("R3 gpo", gpo, VEC[v][3:2]);
            chk("R6 shut", shut, VEC[v][1:0]);
            read1(rb);
            chk("R9 readback", rb, VEC[v][27:20]);
        end

        // R1 wrong address: no acknowledge, nothing changes
        bus_start();
        send_byte(8'h58, nk); chk("R1 foreign addr nack", nk, 1);
        send_byte(8'h00, nk); chk("R1 still silent", nk, 1);
        send_byte(8'h55, nk);
        bus_stop();
        chk("R1 wiper_a kept", wa, 8'h01);

        // R7 truncated write: instruction only
        bus_start();
        send_byte(WR_ADDR, nk);
        send_byte(8'h18, nk); chk("R3 instr ack", nk, 0);
        bus_stop();
        chk("R7 wiper_a kept", wa, 8'h01);
        chk("R3 gpo from instr", gpo, 2'b11);
        chk("R6 shut cleared", shut, 2'b00);

        // R5 midscale on channel B without data
        bus_start();
        send_byte(WR_ADDR, nk);
        send_byte(8'hC0, nk);
        bus_stop();
        chk("R5 wiper_b mid", wb, 8'h80);
        chk("R5 wiper_a untouched", wa, 8'h01);

        // R8 extra byte refused
        bus_start();
        send_byte(WR_ADDR, nk);
        send_byte(8'h00, nk);
        send_byte(8'h22, nk);
        send_byte(8'h99, nk); chk("R8 extra byte nack", nk, 1);
        bus_stop();
        chk("R8 wiper_a", wa, 8'h22);
        chk("R8 wiper_b", wb, 8'h80);

        // R9 read with master acknowledge then non-acknowledge
        bus_start();
        send_byte(RD_ADDR, nk);
        recv_byte(1'b1, rb);
        recv_byte(1'b0, rb2);
        chk("R9 first byte", rb, 8'h22);
        chk("R9 repeated byte", rb2, 8'h22);
        qwait();
        chk("R9 released after nack", sda_oe, 0);
        bus_stop();

        // R2 repeated start in mid data byte, then R7 no change
        bus_start();
        send_byte(WR_ADDR, nk);
        send_byte(8'h80, nk);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(RD_ADDR, nk); chk("R2 addr after restart", nk, 0);
        recv_byte(1'b0, rb);
        bus_stop();
        chk("R2 read selected b", rb, 8'h80);
        chk("R7 wiper_b kept", wb, 8'h80);
        chk("R7 wiper_a kept", wa, 8'h22);

        // R6 shutdown pin
        shdn_n = 1'b0;
        qwait();
        chk("R6 pin shut", shut, 2'b11);
        shdn_n = 1'b1;
        qwait();
        chk("R6 pin released", shut, 2'b00);

        chk("R11 sda change while scl high", r11_viol, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule